// File: doc/BRIEF.md
# Writable Page Probe Scanner

This block masters a word-addressed memory port whose address space is split into equal pages of 4096 words. On a start pulse it walks the pages in ascending order and probes each page at its highest word, the location that holds the page checksum. The probe reads that word, writes back its bitwise complement, and reads the same word again. If the second value differs from the first, the page accepted the write and is classed as writable RAM. If both values match, the page is classed as read-only. This also covers a read-only module that shadows RAM behind it.

The complemented word stays in place, because the checksum can be rebuilt later. Every RAM page found gets a block number, counting up in page order, and the total number of RAM pages is reported. Software or a controller can start a new scan whenever modules may have been plugged or pulled, and the new map replaces the old one. Each memory access waits for an acknowledge, so the memory may take any number of cycles to answer.

Top module: `ramprobe_scan`

## Requirements
- R1: While reset is asserted and after it is released, `page_ram`, `page_blk` and `ram_count` are all zero, `done` is low and `mem_req` is low.
- R2: Every access addresses word 0xFFF of the page under test, so the page index is in `mem_addr[15:12]` and the low 12 bits are all ones. No other address is ever written.
- R3: For each page the block makes exactly three accesses in this order: a read, a write of the complement of the value read, and a second read. Pages are handled in ascending order, and one scan makes 3 × NPAGE accesses.
- R4: Bit p of `page_ram` is 1 (RAM) when the second read of page p differs from the first, and 0 (ROM) when they are equal.
- R5: The 4-bit field p of `page_blk` (bits 4p+3..4p) holds, for a RAM page, the number of RAM pages with a lower index. For a ROM page the field is 0. `ram_count` is the total number of RAM pages, from 0 to 16.
- R6: A request keeps `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stable until the cycle in which `mem_ack` is high. Read data is taken from `mem_rdata` in that cycle.
- R7: `done` is high for exactly one cycle, after the last page has been classified. From then on all map outputs stay unchanged until the next accepted start.
- R8: A start pulse that arrives while a scan is running is ignored. The scan continues unchanged, gives one `done`, and makes no extra accesses.
- R9: A start accepted in idle clears the map and runs a full rescan, so a change in which pages accept writes shows up in the next map.
- R10: After a scan, the probed word of each RAM page holds the complement of its earlier value. The word is not restored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts a scan when idle |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Word address |
| mem_wdata | output | 10 | Write data |
| mem_ack | input | 1 | Access accepted; read data valid |
| mem_rdata | input | 10 | Read data |
| done | output | 1 | One-cycle end-of-scan pulse |
| page_ram | output | 16 | Per-page RAM flag |
| page_blk | output | 64 | Per-page block number, 4 bits each |
| ram_count | output | 5 | Number of RAM pages found |

## Verification
A wrong page index or a wrong state in the sequencer shows up in the very next access, as a wrong address, a missing complement or a wrong access order. The memory model in the bench records each of these as it happens. A wrong compare result or a slip in the block counter shows up in the map at the single `done` cycle. The bench checks the map there against values it works out itself from the set of pages that ignore writes. A lost or repeated scan shows up as a wrong access total or a second `done` pulse within a few dozen cycles.

// File: rtl/ramprobe_pkg.sv
package ramprobe_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RD1  = 3'd1,
    ST_WR   = 3'd2,
    ST_RD2  = 3'd3,
    ST_DONE = 3'd4
  } scan_st_e;
endpackage

// File: rtl/ramprobe_seq.sv
module ramprobe_seq
  import ramprobe_pkg::*;
#(
  parameter int NPAGE   = 16,
  parameter int WORD_W  = 10,
  parameter int PAGE_AW = 12,
  localparam int PG_W   = $clog2(NPAGE),
  localparam int ADDR_W = PAGE_AW + PG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              clr,
  output logic              upd,
  output logic [PG_W-1:0]   upd_page,
  output logic              upd_ram,
  output logic              done
);
  localparam logic [PG_W-1:0] LAST_PG = PG_W'(NPAGE - 1);

  scan_st_e          st_q, st_d;
  logic [PG_W-1:0]   pg_q, pg_d;
  logic [WORD_W-1:0] first_q;
  logic              pg_en, first_en;

  // next-state logic
  always_comb begin
    st_d  = st_q;
    pg_d  = pg_q;
    pg_en = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start) begin
        st_d  = ST_RD1;
        pg_d  = '0;
        pg_en = 1'b1;
      end
      ST_RD1: if (mem_ack) st_d = ST_WR;
      ST_WR:  if (mem_ack) st_d = ST_RD2;
      ST_RD2: if (mem_ack) begin
        if (pg_q == LAST_PG) begin
          st_d = ST_DONE;
        end else begin
          st_d  = ST_RD1;
          pg_d  = pg_q + PG_W'(1);
          pg_en = 1'b1;
        end
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  assign first_en = (st_q == ST_RD1) && mem_ack;

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      pg_q    <= '0;
      first_q <= '0;
    end else begin
      st_q <= st_d;
      if (pg_en)    pg_q    <= pg_d;
      if (first_en) first_q <= mem_rdata;
    end
  end

  // memory port
  assign mem_req   = (st_q == ST_RD1) || (st_q == ST_WR) || (st_q == ST_RD2);
  assign mem_we    = (st_q == ST_WR);
  assign mem_addr  = {pg_q, {PAGE_AW{1'b1}}};
  assign mem_wdata = ~first_q;

  // map interface
  assign clr      = (st_q == ST_IDLE) && start;
  assign upd      = (st_q == ST_RD2) && mem_ack;
  assign upd_page = pg_q;
  assign upd_ram  = (mem_rdata != first_q);
  assign done     = (st_q == ST_DONE);

  // R2: only the top word of a page is ever addressed
  a_r2_last_word: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (&mem_addr[PAGE_AW-1:0]));

  // R6: a pending request holds still until acknowledged
  a_r6_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                               && $stable(mem_wdata)));

  // R7: end-of-scan pulse lasts one cycle
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: a start during a scan does not restart the page walk
  a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && start && !mem_ack) |=> $stable(mem_addr));
endmodule

// File: rtl/ramprobe_map.sv
module ramprobe_map #(
  parameter int NPAGE  = 16,
  localparam int PG_W  = $clog2(NPAGE),
  localparam int BLK_W = PG_W,
  localparam int CNT_W = $clog2(NPAGE + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   upd,
  input  logic [PG_W-1:0]        upd_page,
  input  logic                   upd_ram,
  output logic [NPAGE-1:0]       page_ram,
  output logic [NPAGE*BLK_W-1:0] page_blk,
  output logic [CNT_W-1:0]       ram_count
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = clr || (upd && upd_ram);
  assign cnt_d  = clr ? '0 : cnt_q + CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  for (genvar p = 0; p < NPAGE; p++) begin : g_page
    logic             ram_q, ram_d;
    logic [BLK_W-1:0] blk_q, blk_d;
    logic             en;

    assign en    = clr || (upd && (upd_page == PG_W'(p)));
    assign ram_d = clr ? 1'b0 : upd_ram;
    assign blk_d = (clr || !upd_ram) ? '0 : cnt_q[BLK_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ram_q <= 1'b0;
        blk_q <= '0;
      end else if (en) begin
        ram_q <= ram_d;
        blk_q <= blk_d;
      end
    end

    assign page_ram[p]                   = ram_q;
    assign page_blk[p*BLK_W +: BLK_W]    = blk_q;
  end

  assign ram_count = cnt_q;

  // R7: map holds whenever no clear or classification arrives
  a_r7_map_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !upd) |=> ($stable(page_ram) && $stable(page_blk) && $stable(ram_count)));

  // R9: an accepted start empties the map
  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (page_ram == '0 && ram_count == '0));
endmodule

// File: rtl/ramprobe_scan.sv
module ramprobe_scan #(
  parameter int NPAGE   = 16,
  parameter int WORD_W  = 10,
  parameter int PAGE_AW = 12,
  localparam int PG_W   = $clog2(NPAGE),
  localparam int BLK_W  = PG_W,
  localparam int CNT_W  = $clog2(NPAGE + 1),
  localparam int ADDR_W = PAGE_AW + PG_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  output logic                   mem_req,
  output logic                   mem_we,
  output logic [ADDR_W-1:0]      mem_addr,
  output logic [WORD_W-1:0]      mem_wdata,
  input  logic                   mem_ack,
  input  logic [WORD_W-1:0]      mem_rdata,
  output logic                   done,
  output logic [NPAGE-1:0]       page_ram,
  output logic [NPAGE*BLK_W-1:0] page_blk,
  output logic [CNT_W-1:0]       ram_count
);
  logic            clr, upd, upd_ram;
  logic [PG_W-1:0] upd_page;

  ramprobe_seq #(.NPAGE(NPAGE), .WORD_W(WORD_W), .PAGE_AW(PAGE_AW)) seq_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .clr(clr), .upd(upd), .upd_page(upd_page), .upd_ram(upd_ram), .done(done)
  );

  ramprobe_map #(.NPAGE(NPAGE)) map_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .upd(upd), .upd_page(upd_page),
    .upd_ram(upd_ram), .page_ram(page_ram), .page_blk(page_blk), .ram_count(ram_count)
  );

  // R5: the running count agrees with the map once the scan ends
  a_r5_count_agrees: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($countones(page_ram) == int'(ram_count)));

  // R1: nothing is requested while the map reports done
  a_r1_quiet_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_req);
endmodule

// File: tb/ramprobe_scan_tb.sv
module ramprobe_scan_tb_top;
  localparam int NPAGE = 16;
  localparam int WW    = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        mem_req, mem_we, mem_ack, done;
  logic [15:0] mem_addr;
  logic [9:0]  mem_wdata, mem_rdata;
  logic [15:0] page_ram;
  logic [63:0] page_blk;
  logic [4:0]  ram_count;

  always #5 clk = ~clk;

  ramprobe_scan dut_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .done(done),
    .page_ram(page_ram), .page_blk(page_blk), .ram_count(ram_count)
  );

  int errors = 0;
  int checks = 0;

  // memory model: pages set in rom_mask ignore writes
  logic [15:0] rom_mask = '0;
  int          lat = 0;
  int          seed = 0;
  logic        mem_clr = 1'b1;
  logic        ack_q = 1'b0;
  logic [9:0]  rdata_q = '0;
  logic [9:0]  xor_q [NPAGE];
  int          wcnt, stray, acks, order_err;
  logic        prev_rd;
  logic [15:0] prev_addr;

  assign mem_ack   = ack_q;
  assign mem_rdata = rdata_q;

  function automatic logic [9:0] base(input int p, input int s);
    return 10'((p * 83 + s * 29 + 5) & 10'h3FF);
  endfunction

  always @(posedge clk) begin
    int pg;
    if (mem_clr) begin
      ack_q <= 1'b0; wcnt <= 0; stray <= 0; acks <= 0; order_err <= 0;
      prev_rd <= 1'b0; prev_addr <= '0;
      for (int i = 0; i < NPAGE; i++) xor_q[i] <= '0;
    end else if (ack_q) begin
      ack_q <= 1'b0; wcnt <= 0;
    end else if (mem_req) begin
      if (wcnt >= lat) begin
        pg = int'(mem_addr[15:12]);
        ack_q <= 1'b1;
        acks  <= acks + 1;
        prev_rd   <= !mem_we;
        prev_addr <= mem_addr;
        if (mem_we) begin
          if (!(&mem_addr[11:0])) stray <= stray + 1;
          else if (!rom_mask[pg]) xor_q[pg] <= mem_wdata ^ base(pg, seed);
          if (!prev_rd || prev_addr != mem_addr ||
              mem_wdata != ~(base(pg, seed) ^ xor_q[pg])) order_err <= order_err + 1;
        end else begin
          rdata_q <= (&mem_addr[11:0]) ? (base(pg, seed) ^ xor_q[pg]) : 10'h155;
        end
      end else begin
        wcnt <= wcnt + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_done(output int cyc);
    cyc = 0;
    while (!done && cyc < 3000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic check_map(input logic [15:0] romm, input string tag);
    logic [15:0] exp_ram;
    logic [63:0] exp_blk;
    logic [9:0]  w;
    int n = 0;
    int bad = 0;
    exp_ram = ~romm;
    exp_blk = '0;
    for (int p = 0; p < NPAGE; p++) begin
      if (exp_ram[p]) begin
        exp_blk[p*4 +: 4] = 4'(n);
        n++;
      end
      w = base(p, seed) ^ xor_q[p];
      if (w != (exp_ram[p] ? ~base(p, seed) : base(p, seed))) bad++;
    end
    check(page_ram == exp_ram, "R4", {tag, " ram map"}, 64'(page_ram), 64'(exp_ram));
    check(page_blk == exp_blk, "R5", {tag, " block numbers"}, page_blk, exp_blk);
    check(ram_count == 5'(n), "R5", {tag, " ram count"}, 64'(ram_count), 64'(n));
    check(bad == 0, "R10", {tag, " probed words"}, 64'(bad), 64'd0);
    check(stray == 0, "R2", {tag, " stray writes"}, 64'(stray), 64'd0);
    check(order_err == 0 && acks == 3 * NPAGE, "R3",
          {tag, " access order/total"}, 64'(acks), 64'(3 * NPAGE));
  endtask

  // {rom pages, ack latency}
  localparam logic [17:0] VEC [6] = '{
    {16'h0000, 2'd0},
    {16'hFFFF, 2'd1},
    {16'hA5A5, 2'd2},
    {16'h0001, 2'd3},
    {16'h8000, 2'd0},
    {16'h3C0F, 2'd1}
  };

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int cyc;
    int dn;
    logic [15:0] s_ram;
    logic [63:0] s_blk;
    logic [4:0]  s_cnt;

    // R1: reset state
    repeat (3) @(negedge clk);
    check(page_ram == '0 && page_blk == '0 && ram_count == '0, "R1", "map in reset",
          {page_ram, page_blk[47:0]}, 64'd0);
    check(!done && !mem_req, "R1", "done/req in reset", {done, mem_req}, 64'd0);
    rst_n = 1'b1;
    mem_clr = 1'b0;
    @(negedge clk);
    check(!mem_req && page_ram == '0, "R1", "idle after release", 64'(mem_req), 64'd0);

    // vector table; each entry is a rescan with a new set of read-only pages (R9)
    for (int v = 0; v < 6; v++) begin
      @(negedge clk) mem_clr = 1'b1;
      rom_mask = VEC[v][17:2];
      lat = int'(VEC[v][1:0]);
      seed = v;
      @(negedge clk) mem_clr = 1'b0;
      pulse_start();
      wait_done(cyc);
      check(done == 1'b1, "R7", $sformatf("vec%0d done seen", v), 64'(done), 64'd1);
      check_map(rom_mask, $sformatf("R9 vec%0d", v));
    end

    // R7: single pulse and outputs stable after done
    s_ram = page_ram; s_blk = page_blk; s_cnt = ram_count;
    dn = 0;
    for (int i = 0; i < 25; i++) begin
      @(negedge clk);
      if (done) dn++;
    end
    check(dn == 0, "R7", "no second done pulse", 64'(dn), 64'd0);
    check(page_ram == s_ram && page_blk == s_blk && ram_count == s_cnt, "R7",
          "map stable after done", 64'(page_ram), 64'(s_ram));

    // R8: start in mid-scan is ignored
    @(negedge clk) mem_clr = 1'b1;
    rom_mask = 16'h0F0F; lat = 2; seed = 9;
    @(negedge clk) mem_clr = 1'b0;
    pulse_start();
    repeat (15) @(negedge clk);
    pulse_start();
    dn = 0;
    for (int i = 0; i < 400; i++) begin
      if (done) dn++;
      @(negedge clk);
    end
    check(dn == 1, "R8", "done pulses with extra start", 64'(dn), 64'd1);
    check(acks == 3 * NPAGE, "R8", "accesses with extra start", 64'(acks), 64'(3 * NPAGE));
    check(page_ram == 16'hF0F0, "R8", "map with extra start", 64'(page_ram), 64'hF0F0);

    // R1: reset in mid-scan clears the map and stops requests
    @(negedge clk) mem_clr = 1'b1;
    rom_mask = 16'h0000; lat = 0; seed = 3;
    @(negedge clk) mem_clr = 1'b0;
    pulse_start();
    repeat (20) @(negedge clk);
    rst_n = 1'b0;
    mem_clr = 1'b1;
    @(negedge clk);
    check(page_ram == '0 && ram_count == '0 && !mem_req && !done, "R1",
          "reset during scan", {page_ram, 11'd0, ram_count, 31'd0, mem_req}, 64'd0);
    rst_n = 1'b1;
    mem_clr = 1'b0;
    repeat (5) @(negedge clk);
    check(!mem_req, "R1", "stays idle after mid-scan reset", 64'(mem_req), 64'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule